// File: doc/BRIEF.md
# Instruction Fetch Next-PC Unit

This block owns the program counter of a single-cycle processor core. It presents the current instruction address on every cycle and, at every rising clock edge, loads the address of the next instruction. There are three candidate next addresses: the sequential one four bytes further on, a relative branch target, and an absolute jump target.

The relative branch target is the incremented PC plus the sign-extended immediate field shifted left by two. The absolute jump target keeps the top address bits of the incremented PC, fills the middle with the instruction's target field and ends in two zero bits.

Control logic drives a branch request and a jump request. The branch request only takes effect when the ALU reports a zero (equal) result. The PC register has no hold input, so it updates on every cycle. Instruction memory, prediction and delay slots are handled elsewhere.

Top module: `fetch_pc_unit`

## Requirements
- R1: While `rst_n` is low at a rising edge, the PC becomes `RESET_PC` (default 0x00000000), whatever the other inputs are.
- R2: With `jump_req` low and `branch_req` low, the PC advances by 4 at each rising edge.
- R3: With `branch_req` high, `alu_zero` high and `jump_req` low, the next PC is (PC + 4) + (sign-extended `br_imm` shifted left by 2).
- R4: With `branch_req` high but `alu_zero` low, the branch is not taken and the next PC is PC + 4, whatever the value of `br_imm`.
- R5: `alu_zero` high with `branch_req` low has no effect, and the next PC is PC + 4.
- R6: With `jump_req` high, the next PC is {(PC + 4)[31:28], `jmp_field`, 2'b00}. The top four bits come from the incremented PC.
- R7: When `jump_req` and a taken branch are both present, the jump target is used.
- R8: Address arithmetic wraps modulo 2^32. A negative immediate moves the PC backward, and may move it below zero into the top of the address space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the PC updates on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| branch_req | input | 1 | Current instruction is a conditional branch |
| alu_zero | input | 1 | ALU equality result (1 = operands equal) |
| jump_req | input | 1 | Current instruction is an absolute jump |
| br_imm | input | 16 | Signed word offset of a branch |
| jmp_field | input | 26 | Word-address field of a jump |
| pc | output | 32 | Current instruction address |

## Verification
The bench builds the block with its default parameters: a 32-bit address, a 16-bit immediate and a 26-bit jump field. With these defaults, a short negative branch from address zero wraps the PC into the top of the address space. That in turn gives a jump whose kept region bits are all ones, so a wrong choice of region source becomes visible. The same widths let a single vector carry both a taken branch and a jump, which checks the priority, and let reset be applied while a jump is requested.

// File: rtl/fetch_pc_pkg.sv
// Package: shared types for the next-PC unit.
// Assumes: one selector value per next-PC source; nothing else is shared.
package fetch_pc_pkg;

    // Source of the value loaded into the PC at the next edge
    typedef enum logic [1:0] {
        NPC_SEQ    = 2'd0,
        NPC_BRANCH = 2'd1,
        NPC_JUMP   = 2'd2
    } npc_src_e;

endpackage

// File: rtl/npc_decode.sv
// Module: npc_decode
// Turns the control requests and the ALU zero flag into a single source
// selection. Jump has priority over a taken branch; a branch counts only
// when the zero flag is set.
// Assumes: the inputs are stable before the clock edge (single-cycle core).
module npc_decode
    import fetch_pc_pkg::*;
(
    input  logic     branch_req,
    input  logic     alu_zero,
    input  logic     jump_req,
    output npc_src_e src
);

    // Priority selection: jump, then taken branch, then sequential
    always_comb begin
        if (jump_req)
            src = NPC_JUMP;
        else if (branch_req && alu_zero)
            src = NPC_BRANCH;
        else
            src = NPC_SEQ;
    end

endmodule

// File: rtl/npc_adders.sv
// Module: npc_adders
// Holds the two address adders: PC + instruction size, and the
// incremented PC plus the sign-extended, word-scaled branch offset.
// Assumes: ADDR_W > IMM_W + WORD_SHIFT; sums wrap modulo 2^ADDR_W.
module npc_adders #(
    parameter int ADDR_W     = 32,
    parameter int IMM_W      = 16,
    parameter int WORD_SHIFT = 2
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic [IMM_W-1:0]  imm,
    output logic [ADDR_W-1:0] pc_plus,
    output logic [ADDR_W-1:0] br_target
);

    localparam int EXT_W = ADDR_W - IMM_W - WORD_SHIFT;
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1) << WORD_SHIFT;

    logic [ADDR_W-1:0] offset;

    // Sign-extend the immediate and scale it from words to bytes
    always_comb begin
        offset = {{EXT_W{imm[IMM_W-1]}}, imm, {WORD_SHIFT{1'b0}}};
    end

    // Sequential adder and branch-target adder
    always_comb begin
        pc_plus   = pc + STEP;
        br_target = pc_plus + offset;
    end

endmodule

// File: rtl/npc_mux.sv
// Module: npc_mux
// Picks the next PC from the sequential value, the branch target, or a
// jump target built from the region bits of the incremented PC and the
// jump field.
// Assumes: REGION_W + TGT_W + WORD_SHIFT == ADDR_W.
module npc_mux
    import fetch_pc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int TGT_W      = 26,
    parameter int WORD_SHIFT = 2,
    parameter int REGION_W   = ADDR_W - TGT_W - WORD_SHIFT
) (
    input  npc_src_e            src,
    input  logic [ADDR_W-1:0]   pc_plus,
    input  logic [ADDR_W-1:0]   br_target,
    input  logic [REGION_W-1:0] region,
    input  logic [TGT_W-1:0]    tgt,
    output logic [ADDR_W-1:0]   next_pc
);

    logic [ADDR_W-1:0] jmp_target;

    // Absolute jump target in the current region
    always_comb begin
        jmp_target = {region, tgt, {WORD_SHIFT{1'b0}}};
    end

    // Three-way next-PC selection
    always_comb begin
        unique case (src)
            NPC_JUMP:   next_pc = jmp_target;
            NPC_BRANCH: next_pc = br_target;
            default:    next_pc = pc_plus;
        endcase
    end

endmodule

// File: rtl/pc_reg.sv
// Module: pc_reg
// The program counter flop. It loads on every rising edge, has no hold
// input, and a synchronous active-low reset forces RESET_PC.
// Assumes: rst_n is synchronous to clk.
module pc_reg #(
    parameter int                ADDR_W   = 32,
    parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] d,
    output logic [ADDR_W-1:0] q
);

    // Unconditional load every cycle, reset has priority
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= RESET_PC;
        else
            q <= d;
    end

endmodule

// File: rtl/fetch_pc_unit.sv
// Module: fetch_pc_unit (top)
// Program counter plus next-address logic for a single-cycle core:
// sequential step, zero-gated relative branch, absolute jump (jump wins).
// Assumes: byte addresses, fixed-size instructions of 2^WORD_SHIFT bytes,
// and ADDR_W == REGION_W + TGT_W + WORD_SHIFT with REGION_W > 0.
module fetch_pc_unit
    import fetch_pc_pkg::*;
#(
    parameter int                ADDR_W     = 32,
    parameter int                IMM_W      = 16,
    parameter int                TGT_W      = 26,
    parameter int                WORD_SHIFT = 2,
    parameter logic [ADDR_W-1:0] RESET_PC   = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              branch_req,
    input  logic              alu_zero,
    input  logic              jump_req,
    input  logic [IMM_W-1:0]  br_imm,
    input  logic [TGT_W-1:0]  jmp_field,
    output logic [ADDR_W-1:0] pc
);

    localparam int REGION_W = ADDR_W - TGT_W - WORD_SHIFT;

    npc_src_e          src;
    logic [ADDR_W-1:0] pc_plus;
    logic [ADDR_W-1:0] br_target;
    logic [ADDR_W-1:0] next_pc;

    npc_decode u_decode (
        .branch_req (branch_req),
        .alu_zero   (alu_zero),
        .jump_req   (jump_req),
        .src        (src)
    );

    npc_adders #(
        .ADDR_W     (ADDR_W),
        .IMM_W      (IMM_W),
        .WORD_SHIFT (WORD_SHIFT)
    ) u_adders (
        .pc        (pc),
        .imm       (br_imm),
        .pc_plus   (pc_plus),
        .br_target (br_target)
    );

    npc_mux #(
        .ADDR_W     (ADDR_W),
        .TGT_W      (TGT_W),
        .WORD_SHIFT (WORD_SHIFT),
        .REGION_W   (REGION_W)
    ) u_mux (
        .src       (src),
        .pc_plus   (pc_plus),
        .br_target (br_target),
        .region    (pc_plus[ADDR_W-1 -: REGION_W]),
        .tgt       (jmp_field),
        .next_pc   (next_pc)
    );

    pc_reg #(
        .ADDR_W   (ADDR_W),
        .RESET_PC (RESET_PC)
    ) u_pc (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (next_pc),
        .q     (pc)
    );

endmodule

// File: rtl/fetch_pc_unit_chk.sv
// Module: fetch_pc_unit_chk
// Checker bound to fetch_pc_unit. It relates the inputs of one cycle to
// the PC seen after the following edge.
// Assumes: rst_n is low at the first rising edge.
module fetch_pc_unit_chk #(
    parameter int                ADDR_W     = 32,
    parameter int                IMM_W      = 16,
    parameter int                TGT_W      = 26,
    parameter int                WORD_SHIFT = 2,
    parameter logic [ADDR_W-1:0] RESET_PC   = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              branch_req,
    input logic              alu_zero,
    input logic              jump_req,
    input logic [IMM_W-1:0]  br_imm,
    input logic [TGT_W-1:0]  jmp_field,
    input logic [ADDR_W-1:0] pc
);

    localparam int EXT_W    = ADDR_W - IMM_W - WORD_SHIFT;
    localparam int REGION_W = ADDR_W - TGT_W - WORD_SHIFT;
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1) << WORD_SHIFT;

    logic [ADDR_W-1:0] exp_off;
    logic [ADDR_W-1:0] exp_seq;

    // Reference offset and sequential value seen from the ports
    always_comb begin
        exp_off = {{EXT_W{br_imm[IMM_W-1]}}, br_imm, {WORD_SHIFT{1'b0}}};
        exp_seq = pc + STEP;
    end

    // R1: reset forces the reset address
    a_r1_reset_value: assert property (@(posedge clk)
        !rst_n |=> pc == RESET_PC);

    // R2, R4, R5: no jump and no taken branch gives a step of one word
    a_r2_sequential: assert property (@(posedge clk) disable iff (!rst_n)
        (!jump_req && !(branch_req && alu_zero)) |=> pc == $past(exp_seq));

    // R3, R8: a taken branch adds the scaled offset to the step
    a_r3_branch_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (!jump_req && branch_req && alu_zero)
            |=> pc == $past(exp_seq) + $past(exp_off));

    // R6, R7: a jump keeps the region bits and loads the field
    a_r6_jump_target: assert property (@(posedge clk) disable iff (!rst_n)
        jump_req |=> pc == {$past(exp_seq[ADDR_W-1 -: REGION_W]),
                            $past(jmp_field), {WORD_SHIFT{1'b0}}});

    // R4: a branch without zero has the same result as no branch
    a_r4_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (!jump_req && branch_req && !alu_zero) |=> pc == $past(pc) + STEP);

endmodule

bind fetch_pc_unit fetch_pc_unit_chk #(
    .ADDR_W     (ADDR_W),
    .IMM_W      (IMM_W),
    .TGT_W      (TGT_W),
    .WORD_SHIFT (WORD_SHIFT),
    .RESET_PC   (RESET_PC)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .branch_req (branch_req),
    .alu_zero   (alu_zero),
    .jump_req   (jump_req),
    .br_imm     (br_imm),
    .jmp_field  (jmp_field),
    .pc         (pc)
);

// File: tb/test_fetch_pc_unit.sv
// Scoreboard bench: the driver pushes the expected PC for each vector.
// The monitor pops one entry 1 ns after each rising edge and compares it.
module test_fetch_pc_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        branch_req, alu_zero, jump_req;
    logic [15:0] br_imm;
    logic [25:0] jmp_field;
    logic [31:0] pc;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic [31:0] model_pc;
    int          n_vec  = 0;
    int          n_fail = 0;
    bit          done   = 1'b0;

    always #2.5 clk = ~clk;

    fetch_pc_unit i_fetch_pc_unit (
        .clk        (clk),
        .rst_n      (rst_n),
        .branch_req (branch_req),
        .alu_zero   (alu_zero),
        .jump_req   (jump_req),
        .br_imm     (br_imm),
        .jmp_field  (jmp_field),
        .pc         (pc)
    );

    // Driver: apply one vector at a falling edge and push the expected PC
    task automatic apply(input bit rst, input bit br, input bit z, input bit j,
                         input logic [15:0] imm, input logic [25:0] tgt,
                         input string tag);
        logic [31:0] step;
        logic [31:0] exp;
        @(negedge clk);
        rst_n = ~rst; branch_req = br; alu_zero = z; jump_req = j;
        br_imm = imm; jmp_field = tgt;
        step = model_pc + 32'd4;
        if (rst)          exp = 32'h0;
        else if (j)       exp = {step[31:28], tgt, 2'b00};
        else if (br && z) exp = step + {{14{imm[15]}}, imm, 2'b00};
        else              exp = step;
        model_pc = exp;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
    endtask

    // Monitor: compare the PC against the scoreboard after each edge
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_vec++;
            if (pc !== e) begin
                n_fail++;
                $display("FAIL %s: pc=%h expected %h", t, pc, e);
            end
        end
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: expired=1 expected 0");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; branch_req = 1'b0; alu_zero = 1'b0; jump_req = 1'b0;
        br_imm = '0; jmp_field = '0; model_pc = '0;
        apply(1, 0, 0, 0, 16'h0,    26'h0,       "R1");
        apply(1, 1, 1, 1, 16'h7,    26'h3FFFFFF, "R1");
        apply(0, 0, 0, 0, 16'h1234, 26'h0,       "R2");
        apply(0, 0, 0, 0, 16'h0,    26'h0,       "R2");
        apply(0, 0, 1, 0, 16'h0040, 26'h0,       "R5");
        apply(0, 1, 0, 0, 16'h0100, 26'h0,       "R4");
        apply(0, 1, 1, 0, 16'h0002, 26'h0,       "R3");
        apply(0, 1, 1, 0, 16'hFFFD, 26'h0,       "R8");
        apply(0, 0, 0, 1, 16'h0,    26'h0ABCDE,  "R6");
        apply(0, 1, 1, 1, 16'h0010, 26'h0000100, "R7");
        apply(1, 0, 0, 0, 16'h0,    26'h0,       "R1");
        apply(0, 1, 1, 0, 16'hFFFC, 26'h0,       "R8");
        apply(0, 0, 0, 1, 16'h0,    26'h0000020, "R6");
        apply(0, 1, 1, 0, 16'h7FFF, 26'h0,       "R3");
        apply(0, 1, 0, 1, 16'h0,    26'h1555555, "R7");
        apply(1, 0, 0, 1, 16'h0,    26'h2AAAAAA, "R1");
        apply(0, 0, 0, 0, 16'h0,    26'h0,       "R2");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule